// File: doc/BRIEF.md
# Two-Phase Watchdog Timer with Startup Grace

This block is a watchdog timer driven by one byte-wide control register. The low three bits of the register pick an operating mode. Each mode combines a startup grace delay with a steady-state watchdog period. One further bit acts as the kick line. Software keeps the watchdog alive by pulsing that bit: it writes the bit high and then writes it low again. If the period runs out with no kick, the block raises a reset request for a fixed number of clocks. It then begins the grace delay again.

All timing is counted in ticks. A tick is a fixed number of system clocks, set by a parameter, and normally equals one second. A parameter selects one of two mode tables. In the first table every mode has a grace delay. The second table also has zero-delay modes. In a zero-delay mode nothing is timed until the first kick arrives. One code of the mode field disables the watchdog, and so does any code that the active table does not define.

Top module: `wdt_grace`

## Requirements
- R1: Out of reset the register reads 0x03, which means disabled. After a write, `rd_data` returns the whole byte last written, including the unused upper bits.
- R2: `wdt_expired` never goes high while the mode field (bits [2:0]) holds 3, or holds a code that the active table does not define.
- R3: With TABLE_SEL = 0 the codes are: 5 = 1-tick delay and 1-tick period; 6 = 10 and 10; 7 = 60 and 60. Without kicks, the first expiry occurs exactly (delay + period) * TICK_DIV clocks after the write that loads the mode.
- R4: With TABLE_SEL = 1 the codes are: 1 = 3 and 3; 2 = 60-tick delay and 1-tick period; 5 = no delay and 1-tick period; 6 = no delay and 10-tick period; 7 = 60-tick delay and 10-tick period.
- R5: Every restart of timing also restarts the tick prescaler. A running delay or period therefore never ends sooner than its nominal number of ticks times TICK_DIV clocks.
- R6: A kick is a write with bit 3 = 0 while the stored bit 3 is 1. During the period phase a kick restarts the period, so expiry comes exactly period * TICK_DIV clocks after the last kick write.
- R7: In a zero-delay mode, loading the mode starts no timing. The first kick starts the period, and expiry comes period * TICK_DIV clocks after that kick.
- R8: Kicks that arrive during the grace delay are accepted but change nothing. Expiry still comes (delay + period) * TICK_DIV clocks after the mode load.
- R9: Only a write that changes bits [2:0] reloads the timing. Other writes, including upper-bit changes, do not. When one write both changes the mode and kicks, the mode load takes effect and the kick is dropped.
- R10: Each expiry holds `wdt_expired` high for exactly PULSE_LEN clocks. The block then re-enters the grace delay, or the wait for a kick in a zero-delay mode. A second expiry follows after the same time again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_data | input | 8 | Byte to write; [2:0] mode, [3] kick |
| rd_data | output | 8 | Current register contents |
| wdt_expired | output | 1 | Watchdog reset request, high for PULSE_LEN clocks per expiry |

## Verification
The bench builds two copies of the block. Both use TICK_DIV = 5 and PULSE_LEN = 3; one selects table 0 and the other table 1. With a tick of five clocks, even the 60-tick delays fit in a few hundred cycles. Every mode of both tables can therefore be run to expiry, and each expiry can be checked against its exact clock count. The short pulse makes the re-entry into the delay or kick-wait phase visible, and a repeated expiry completes within a single test step.

// File: rtl/wdt_grace_pkg.sv
package wdt_grace_pkg;

  localparam int REG_W    = 8;
  localparam int MODE_W   = 3;
  localparam int KICK_POS = 3;
  localparam int TIME_W   = 8;

  localparam logic [MODE_W-1:0] MODE_OFF  = 3'd3;
  localparam logic [REG_W-1:0]  REG_RESET = {{(REG_W-MODE_W){1'b0}}, MODE_OFF};

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ARMED,
    ST_DELAY,
    ST_PERIOD,
    ST_FIRE
  } phase_e;

  typedef struct packed {
    logic              valid;
    logic [TIME_W-1:0] delay;
    logic [TIME_W-1:0] period;
  } mode_cfg_t;

  // Mode tables: delay and period in ticks.
  function automatic mode_cfg_t mode_lookup(input int tsel, input logic [MODE_W-1:0] code);
    mode_cfg_t c;
    c = '0;
    if (tsel == 0) begin
      case (code)
        3'd5: c = '{1'b1, 8'd1,  8'd1};
        3'd6: c = '{1'b1, 8'd10, 8'd10};
        3'd7: c = '{1'b1, 8'd60, 8'd60};
        default: c = '0;
      endcase
    end else begin
      case (code)
        3'd1: c = '{1'b1, 8'd3,  8'd3};
        3'd2: c = '{1'b1, 8'd60, 8'd1};
        3'd5: c = '{1'b1, 8'd0,  8'd1};
        3'd6: c = '{1'b1, 8'd0,  8'd10};
        3'd7: c = '{1'b1, 8'd60, 8'd10};
        default: c = '0;
      endcase
    end
    if (code == MODE_OFF) c.valid = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/wdt_grace_prescaler.sv
module wdt_grace_prescaler #(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = !clear;
    end else begin : g_count
      localparam int PC_W = $clog2(TICK_DIV);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(TICK_DIV - 1);
      logic [PC_W-1:0] pc_q;

      assign tick = (pc_q == PC_LAST) && !clear;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       pc_q <= '0;
        else if (clear || pc_q == PC_LAST) pc_q <= '0;
        else                               pc_q <= pc_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_grace_regs.sv
module wdt_grace_regs
  import wdt_grace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [MODE_W-1:0] cur_code,
  output logic              load_evt,
  output logic              kick_evt
);
  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= REG_RESET;
    else if (wr_en) reg_q <= wr_data;
  end

  assign rd_data  = reg_q;
  assign cur_code = reg_q[MODE_W-1:0];
  // a change of the mode field reloads the timer
  assign load_evt = wr_en && (wr_data[MODE_W-1:0] != reg_q[MODE_W-1:0]);
  // a kick completes when a write drops the stored kick bit
  assign kick_evt = wr_en && reg_q[KICK_POS] && !wr_data[KICK_POS];
endmodule

// File: rtl/wdt_grace_timer.sv
module wdt_grace_timer
  import wdt_grace_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int PULSE_LEN = 16,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_evt,
  input  logic              kick_evt,
  input  logic [MODE_W-1:0] load_code,
  input  logic [MODE_W-1:0] cur_code,
  output phase_e            phase,
  output logic              restart
);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_LEN - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mode_cfg_t        new_cfg, cur_cfg;

  function automatic logic last_step(input logic [CNT_W-1:0] c, input logic [TIME_W-1:0] lim);
    return (c + 1'b1) == CNT_W'(lim);
  endfunction

  assign new_cfg = mode_lookup(TABLE_SEL, load_code);
  assign cur_cfg = mode_lookup(TABLE_SEL, cur_code);

  // prescaler restart: kept apart from the phase logic that consumes tick
  always_comb begin
    restart = 1'b0;
    if (load_evt)                                          restart = 1'b1;
    else if (kick_evt && (ph_q == ST_PERIOD || ph_q == ST_ARMED)) restart = 1'b1;
    else if (ph_q == ST_FIRE && cnt_q == PULSE_LAST)       restart = 1'b1;
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (load_evt) begin
      cnt_d = '0;
      if (!new_cfg.valid)          ph_d = ST_OFF;
      else if (new_cfg.delay == '0) ph_d = ST_ARMED;
      else                          ph_d = ST_DELAY;
    end else begin
      case (ph_q)
        ST_ARMED: begin
          if (kick_evt) begin
            ph_d  = ST_PERIOD;
            cnt_d = '0;
          end
        end
        ST_DELAY: begin
          if (tick) begin
            if (last_step(cnt_q, cur_cfg.delay)) begin
              ph_d  = ST_PERIOD;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PERIOD: begin
          if (kick_evt) begin
            cnt_d = '0;
          end else if (tick) begin
            if (last_step(cnt_q, cur_cfg.period)) begin
              ph_d  = ST_FIRE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_FIRE: begin
          if (cnt_q == PULSE_LAST) begin
            cnt_d = '0;
            ph_d  = (cur_cfg.delay == '0) ? ST_ARMED : ST_DELAY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/wdt_grace.sv
module wdt_grace
  import wdt_grace_pkg::*;
#(
  parameter int TABLE_SEL = 0,
  parameter int TICK_DIV  = 50_000_000,
  parameter int PULSE_LEN = 16,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_expired
);
  logic              tick;
  logic              restart;
  logic              load_evt;
  logic              kick_evt;
  logic [MODE_W-1:0] cur_code;
  phase_e            phase;

  // named phase views used by the checker
  logic in_armed, in_delay, in_period;

  wdt_grace_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cur_code (cur_code),
    .load_evt (load_evt),
    .kick_evt (kick_evt)
  );

  wdt_grace_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .tick  (tick)
  );

  wdt_grace_timer #(
    .TABLE_SEL (TABLE_SEL),
    .PULSE_LEN (PULSE_LEN),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_evt  (load_evt),
    .kick_evt  (kick_evt),
    .load_code (wr_data[MODE_W-1:0]),
    .cur_code  (cur_code),
    .phase     (phase),
    .restart   (restart)
  );

  assign in_armed    = (phase == ST_ARMED);
  assign in_delay    = (phase == ST_DELAY);
  assign in_period   = (phase == ST_PERIOD);
  assign wdt_expired = (phase == ST_FIRE);
endmodule

// File: rtl/wdt_grace_checks.sv
module wdt_grace_checks #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       wdt_expired,
  input logic       load_evt,
  input logic       kick_evt,
  input logic       tick,
  input logic       restart,
  input logic       in_armed,
  input logic       in_delay,
  input logic       in_period
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hi_cnt <= 0;
    else if (wdt_expired) hi_cnt <= hi_cnt + 1;
    else                  hi_cnt <= 0;
  end

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:0] == 3'd3) |-> !wdt_expired);

  assert_fire_from_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_expired) |-> ($past(in_period) && $past(tick) && !$past(load_evt)));

  assert_restart_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !tick);

  assert_kick_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_period && kick_evt && !load_evt) |=> (in_period && !wdt_expired));

  assert_armed_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_armed && !kick_evt && !load_evt) |=> in_armed);

  assert_delay_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_delay && !load_evt && !tick) |=> in_delay);

  assert_pulse_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= PULSE_LEN);

  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wdt_expired) && !$past(load_evt)) |-> hi_cnt == PULSE_LEN);
endmodule

bind wdt_grace wdt_grace_checks #(.PULSE_LEN(PULSE_LEN)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .wdt_expired (wdt_expired),
  .load_evt    (load_evt),
  .kick_evt    (kick_evt),
  .tick        (tick),
  .restart     (restart),
  .in_armed    (in_armed),
  .in_delay    (in_delay),
  .in_period   (in_period)
);

// File: tb/wdt_grace_bench.sv
module wdt_grace_bench;
  localparam int T  = 5;
  localparam int PL = 3;
  localparam int A  = 0;
  localparam int B  = 1;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_a = 1'b0, we_b = 1'b0;
  logic [7:0] wdat = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic       exp_a, exp_b;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_grace #(.TABLE_SEL(0), .TICK_DIV(T), .PULSE_LEN(PL)) u_wdt_grace (
    .clk(clk), .rst_n(rst_n), .wr_en(we_a), .wr_data(wdat),
    .rd_data(rd_a), .wdt_expired(exp_a));

  wdt_grace #(.TABLE_SEL(1), .TICK_DIV(T), .PULSE_LEN(PL)) u_wdt_grace_tbl1 (
    .clk(clk), .rst_n(rst_n), .wr_en(we_b), .wr_data(wdat),
    .rd_data(rd_b), .wdt_expired(exp_b));

  // Mode timing restated from the requirements (R3, R4)
  function automatic int delay_of(input int tbl, input int code);
    if (tbl == 0) return (code == 5) ? 1 : (code == 6) ? 10 : (code == 7) ? 60 : 0;
    case (code)
      1: return 3;
      2: return 60;
      7: return 60;
      default: return 0;
    endcase
  endfunction

  function automatic int period_of(input int tbl, input int code);
    if (tbl == 0) return (code == 5) ? 1 : (code == 6) ? 10 : (code == 7) ? 60 : 0;
    case (code)
      1: return 3;
      2: return 1;
      5: return 1;
      6: return 10;
      7: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_of(input int which);
    return (which == A) ? exp_a : exp_b;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // write lands on posedge number t
  task automatic wr_at(input int which, input logic [7:0] d, input int t);
    wait_until(t - 1);
    wdat = d;
    if (which == A) we_a = 1'b1; else we_b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we_a = 1'b0;
    we_b = 1'b0;
  endtask

  task automatic exp_at(input int which, input int t, input string req);
    wait_until(t - 1);
    check(req, int'(exp_of(which)), 0);
    wait_until(t);
    check(req, int'(exp_of(which)), 1);
  endtask

  task automatic pulse_end(input int which, input int t, input string req);
    wait_until(t + PL - 1);
    check(req, int'(exp_of(which)), 1);
    wait_until(t + PL);
    check(req, int'(exp_of(which)), 0);
  endtask

  task automatic quiet_for(input int which, input int n, input string req);
    bit seen;
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (exp_of(which)) seen = 1'b1;
    end
    check(req, int'(seen), 0);
  endtask

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, k, t1;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", int'(rd_a), 8'h03);
    check("R1", int'(rd_b), 8'h03);
    check("R2", int'(exp_a), 0);
    check("R2", int'(exp_b), 0);

    // R1 readback of upper bits, R2 still disabled
    wr_at(B, 8'hF3, cyc + 1);
    check("R1", int'(rd_b), 8'hF3);
    quiet_for(B, 400, "R2");

    // R3 code 5 on table 0, R10 pulse and repeat
    e = cyc + 1; wr_at(A, 8'h05, e);
    t1 = e + (1 + 1) * T;
    exp_at(A, t1, "R3");
    pulse_end(A, t1, "R10");
    exp_at(A, t1 + PL + 2 * T, "R10");
    wr_at(A, 8'h03, cyc + 1);
    quiet_for(A, 300, "R2");

    // R8 kick inside grace delay does not shorten it
    e = cyc + 1; wr_at(A, 8'h06, e);
    wr_at(A, 8'h0E, e + 30);
    wr_at(A, 8'h06, e + 31);
    exp_at(A, e + 20 * T, "R8");

    // R9 upper-bit write with same mode does not reload
    wr_at(A, 8'h03, cyc + 1);
    e = cyc + 1; wr_at(A, 8'h06, e);
    wr_at(A, 8'h46, e + 60);
    check("R1", int'(rd_a), 8'h46);
    exp_at(A, e + 20 * T, "R9");

    // R9 mode load wins over a simultaneous kick
    wr_at(A, 8'h4E, cyc + 1);
    k = cyc + 1; wr_at(A, 8'h05, k);
    exp_at(A, k + 2 * T, "R9");

    // R2 code undefined in table 0
    wr_at(A, 8'h02, cyc + 1);
    check("R1", int'(rd_a), 8'h02);
    quiet_for(A, 700, "R2");

    // R4 table 1 delayed modes
    for (int i = 0; i < 3; i++) begin
      int code;
      code = (i == 0) ? 2 : (i == 1) ? 1 : 7;
      wr_at(B, 8'h03, cyc + 1);
      e = cyc + 1; wr_at(B, 8'(code), e);
      exp_at(B, e + (delay_of(1, code) + period_of(1, code)) * T, "R4");
    end

    // R7 zero-delay code 5 on table 1
    wr_at(B, 8'h03, cyc + 1);
    wr_at(B, 8'h05, cyc + 1);
    quiet_for(B, 400, "R7");
    wr_at(B, 8'h0D, cyc + 1);
    k = cyc + 1; wr_at(B, 8'h05, k);
    exp_at(B, k + period_of(1, 5) * T, "R7");
    pulse_end(B, k + period_of(1, 5) * T, "R10");
    quiet_for(B, 200, "R10");
    wr_at(B, 8'h0D, cyc + 1);
    k = cyc + 1; wr_at(B, 8'h05, k);
    exp_at(B, k + T, "R7");

    // R7 code 6 on table 1: load waits for kick
    wr_at(B, 8'h06, cyc + 1);
    quiet_for(B, 100, "R7");
    wr_at(B, 8'h0E, cyc + 1);
    k = cyc + 1; wr_at(B, 8'h06, k);
    exp_at(B, k + period_of(1, 6) * T, "R4");

    // R5 R6 random kicks during the period on table 0
    for (int it = 0; it < 12; it++) begin
      int code, d, p, nk, last, gap;
      code = 5 + int'($urandom % 3);
      d = delay_of(0, code);
      p = period_of(0, code);
      wr_at(A, 8'h03, cyc + 1);
      e = cyc + 1; wr_at(A, 8'(code), e);
      last = e + d * T;
      nk = int'($urandom % 4);
      for (int j = 0; j < nk; j++) begin
        gap = 2 + int'($urandom % (p * T - 2));
        k = last + gap;
        wr_at(A, 8'(code | 8), k - 1);
        wr_at(A, 8'(code), k);
        last = k;
      end
      exp_at(A, last + p * T, "R5 R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule